// File: doc/BRIEF.md
# Iterative DES Block Cipher Core

This core encrypts or decrypts a single 64-bit block under a 64-bit key word. Only 56 bits of that key word take part; the low bit of every byte is a parity position and is discarded. One round datapath is reused for all sixteen rounds. A round register pair carries the two 32-bit halves from round to round. A 56-bit key register holds the two 28-bit rotating halves, and the round key is derived from it.

A build-time parameter selects how a round is built. With `SEQ_ROUND = 0` the whole round is one combinational path and completes every clock. With `SEQ_ROUND = 1` the round runs as five one-clock sub-steps in this order: expand, key mix, substitute, permute, and merge with swap. Each intermediate value is held in its own register.

A host raises `start_i` for one clock while the core is idle. It sets `data_i`, `key_i` and the direction on `decrypt_i` in that same clock. The core then holds `busy_o` high. When the result is ready it raises `done_o` for one clock. `result_o` keeps that value until the next operation completes.

Top module: `des_iter_core`

## Requirements
- R1: While reset is asserted and directly after it is released, `busy_o`, `done_o` and `result_o` are all zero.
- R2: With `decrypt_i = 0` at start, `result_o` at the `done_o` pulse equals the standard DES encryption of `data_i` under `key_i`. Bit 63 is the first bit of both the block and the key.
- R3: With `decrypt_i = 1` at start, `result_o` at the `done_o` pulse equals the standard DES decryption of `data_i` under `key_i`. This is the exact inverse of R2 under the same key.
- R4: Key bits 0, 8, 16, 24, 32, 40, 48 and 56 have no effect on the result.
- R5: `done_o` rises exactly LAT clocks after the rising edge that accepts `start_i`. LAT is 16 for `SEQ_ROUND = 0` and 80 for `SEQ_ROUND = 1`, which is five clocks per round.
- R6: `done_o` is high for exactly one clock per operation, and `busy_o` is low whenever `done_o` is high.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The running operation keeps its latched data, key and direction, and no extra `done_o` pulse occurs.
- R8: `result_o` changes only in a clock where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation; accepted only while not busy |
| decrypt_i | input | 1 | 0 encrypts, 1 decrypts; sampled with start_i |
| data_i | input | 64 | Input block; sampled with start_i |
| key_i | input | 64 | Key word including parity positions; sampled with start_i |
| busy_o | output | 1 | High while rounds are running |
| done_o | output | 1 | One-clock pulse when result_o is new |
| result_o | output | 64 | Last completed output block |

## Verification
The core is driven with published known-answer pairs: a textbook key and block, a key that maps a repeated byte block to zero, and the all-zero and all-one patterns. Together these expose errors in the substitution tables, the permutations and the rotation schedule. The same pairs are decrypted to check the reversed key order separately from the encrypt path. Keys whose parity bits are inverted show that those positions are dropped. Start pulses that carry a different direction, block and key while busy show that the latched operands are kept and that no second completion appears.

// File: rtl/des_pkg.sv
package des_pkg;

    localparam int BLOCK_W  = 64;
    localparam int HALF_W   = BLOCK_W / 2;
    localparam int KEYIN_W  = 64;
    localparam int KEY_W    = 56;
    localparam int CD_W     = KEY_W / 2;
    localparam int SUBKEY_W = 48;
    localparam int ROUNDS   = 16;
    localparam int RND_W    = $clog2(ROUNDS);
    localparam int SBOX_N   = 8;
    localparam int SBOX_IN  = SUBKEY_W / SBOX_N;
    localparam int SBOX_OUT = HALF_W / SBOX_N;
    localparam int SBOX_ENT = 1 << SBOX_IN;
    localparam int SBOX_BITS = SBOX_ENT * SBOX_OUT;
    localparam int SEQ_STEPS = 5;
    localparam int STEP_W   = $clog2(SEQ_STEPS);

    typedef enum logic [STEP_W-1:0] {
        ST_EXPAND = 3'd0,
        ST_MIX    = 3'd1,
        ST_SUBST  = 3'd2,
        ST_PERM   = 3'd3,
        ST_MERGE  = 3'd4
    } step_e;

    // Source positions, numbered from 1 at the MSB.
    localparam int RP_TAB [HALF_W] = '{
        16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
        2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25
    };

    localparam int KSEL1_TAB [KEY_W] = '{
        57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
        10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
        14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4
    };

    localparam int KSEL2_TAB [SUBKEY_W] = '{
        14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
        23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };

    // Each box: 64 nibbles, entry row*16+col at the top nibble first.
    localparam logic [SBOX_BITS-1:0] SBOX_TAB [SBOX_N] = '{
        256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
        256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
        256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
        256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
        256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
        256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
        256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
        256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
    };

    function automatic int ip_src(input int i);
        int row;
        int col;
        row = i / 8;
        col = i % 8;
        if (row < 4) return 58 + 2 * row - 8 * col;
        return 57 + 2 * (row - 4) - 8 * col;
    endfunction

    function automatic logic [BLOCK_W-1:0] perm_in(input logic [BLOCK_W-1:0] x);
        logic [BLOCK_W-1:0] y;
        for (int i = 0; i < BLOCK_W; i++) y[BLOCK_W-1-i] = x[BLOCK_W-ip_src(i)];
        return y;
    endfunction

    function automatic logic [BLOCK_W-1:0] perm_out(input logic [BLOCK_W-1:0] x);
        logic [BLOCK_W-1:0] y;
        for (int i = 0; i < BLOCK_W; i++) y[BLOCK_W-ip_src(i)] = x[BLOCK_W-1-i];
        return y;
    endfunction

    function automatic logic [SUBKEY_W-1:0] expand(input logic [HALF_W-1:0] x);
        logic [SUBKEY_W-1:0] y;
        int src;
        for (int j = 0; j < SUBKEY_W; j++) begin
            src = 4 * (j / 6) + (j % 6);
            if (src == 0) src = HALF_W;
            if (src == HALF_W + 1) src = 1;
            y[SUBKEY_W-1-j] = x[HALF_W-src];
        end
        return y;
    endfunction

    function automatic logic [HALF_W-1:0] round_perm(input logic [HALF_W-1:0] x);
        logic [HALF_W-1:0] y;
        for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-RP_TAB[i]];
        return y;
    endfunction

    function automatic logic [KEY_W-1:0] key_sel1(input logic [KEYIN_W-1:0] x);
        logic [KEY_W-1:0] y;
        for (int i = 0; i < KEY_W; i++) y[KEY_W-1-i] = x[KEYIN_W-KSEL1_TAB[i]];
        return y;
    endfunction

    function automatic logic [SUBKEY_W-1:0] key_sel2(input logic [KEY_W-1:0] x);
        logic [SUBKEY_W-1:0] y;
        for (int i = 0; i < SUBKEY_W; i++) y[SUBKEY_W-1-i] = x[KEY_W-KSEL2_TAB[i]];
        return y;
    endfunction

    function automatic logic [HALF_W-1:0] substitute(input logic [SUBKEY_W-1:0] x);
        logic [HALF_W-1:0] y;
        logic [SBOX_IN-1:0] grp;
        int idx;
        for (int n = 0; n < SBOX_N; n++) begin
            grp = x[SUBKEY_W-1-SBOX_IN*n -: SBOX_IN];
            idx = int'({grp[5], grp[0], grp[4:1]});
            y[HALF_W-1-SBOX_OUT*n -: SBOX_OUT] = SBOX_TAB[n][SBOX_BITS-1-SBOX_OUT*idx -: SBOX_OUT];
        end
        return y;
    endfunction

    function automatic logic single_shift(input logic [RND_W-1:0] rnd);
        return (rnd == 4'd0) || (rnd == 4'd1) || (rnd == 4'd8) || (rnd == 4'd15);
    endfunction

    function automatic logic [CD_W-1:0] rot_left(input logic [CD_W-1:0] x, input logic one);
        return one ? {x[CD_W-2:0], x[CD_W-1]} : {x[CD_W-3:0], x[CD_W-1:CD_W-2]};
    endfunction

    function automatic logic [CD_W-1:0] rot_right(input logic [CD_W-1:0] x, input logic one);
        return one ? {x[0], x[CD_W-1:1]} : {x[1:0], x[CD_W-1:2]};
    endfunction

endpackage

// File: rtl/des_key_step.sv
module des_key_step
    import des_pkg::*;
(
    input  logic [KEY_W-1:0]    cd_i,
    input  logic [RND_W-1:0]    rnd_i,
    input  logic                dec_i,
    output logic [SUBKEY_W-1:0] subkey_o,
    output logic [KEY_W-1:0]    cd_next_o
);

    logic [CD_W-1:0]  c_cur;
    logic [CD_W-1:0]  d_cur;
    logic [KEY_W-1:0] fwd;
    logic [RND_W-1:0] back_rnd;

    always_comb begin
        c_cur    = cd_i[KEY_W-1:CD_W];
        d_cur    = cd_i[CD_W-1:0];
        back_rnd = RND_W'(ROUNDS - 1) - rnd_i;
        fwd      = {rot_left(c_cur, single_shift(rnd_i)), rot_left(d_cur, single_shift(rnd_i))};
        if (!dec_i) begin
            // Forward: rotate first, then select.
            subkey_o  = key_sel2(fwd);
            cd_next_o = fwd;
        end else begin
            // Reverse: select first, then undo the matching forward rotation.
            subkey_o  = key_sel2(cd_i);
            cd_next_o = {rot_right(c_cur, single_shift(back_rnd)),
                         rot_right(d_cur, single_shift(back_rnd))};
        end
    end

endmodule

// File: rtl/des_round_comb.sv
module des_round_comb
    import des_pkg::*;
(
    input  logic                en_i,
    input  logic [HALF_W-1:0]   l_i,
    input  logic [HALF_W-1:0]   r_i,
    input  logic [SUBKEY_W-1:0] subkey_i,
    output logic                commit_o,
    output logic [HALF_W-1:0]   l_o,
    output logic [HALF_W-1:0]   r_o
);

    logic [SUBKEY_W-1:0] mixed;
    logic [HALF_W-1:0]   f_out;

    always_comb begin
        mixed    = expand(r_i) ^ subkey_i;
        f_out    = round_perm(substitute(mixed));
        commit_o = en_i;
        l_o      = r_i;
        r_o      = l_i ^ f_out;
    end

endmodule

// File: rtl/des_round_seq.sv
module des_round_seq
    import des_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic [HALF_W-1:0]   l_i,
    input  logic [HALF_W-1:0]   r_i,
    input  logic [SUBKEY_W-1:0] subkey_i,
    output logic                commit_o,
    output logic [HALF_W-1:0]   l_o,
    output logic [HALF_W-1:0]   r_o
);

    typedef struct packed {
        step_e               step;
        logic [SUBKEY_W-1:0] ex;
        logic [SUBKEY_W-1:0] mx;
        logic [HALF_W-1:0]   sb;
        logic [HALF_W-1:0]   pm;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    always_comb begin
        seq_d    = seq_q;
        commit_o = 1'b0;
        if (en_i) begin
            unique case (seq_q.step)
                ST_EXPAND: begin
                    seq_d.ex   = expand(r_i);
                    seq_d.step = ST_MIX;
                end
                ST_MIX: begin
                    seq_d.mx   = seq_q.ex ^ subkey_i;
                    seq_d.step = ST_SUBST;
                end
                ST_SUBST: begin
                    seq_d.sb   = substitute(seq_q.mx);
                    seq_d.step = ST_PERM;
                end
                ST_PERM: begin
                    seq_d.pm   = round_perm(seq_q.sb);
                    seq_d.step = ST_MERGE;
                end
                ST_MERGE: begin
                    commit_o   = 1'b1;
                    seq_d.step = ST_EXPAND;
                end
                default: seq_d.step = ST_EXPAND;
            endcase
        end
        l_o = r_i;
        r_o = l_i ^ seq_q.pm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{step: ST_EXPAND, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/des_iter_core.sv
module des_iter_core
    import des_pkg::*;
#(
    parameter bit SEQ_ROUND = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               decrypt_i,
    input  logic [BLOCK_W-1:0] data_i,
    input  logic [KEYIN_W-1:0] key_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [BLOCK_W-1:0] result_o
);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic               dec;
        logic [RND_W-1:0]   rnd;
        logic [HALF_W-1:0]  l;
        logic [HALF_W-1:0]  r;
        logic [KEY_W-1:0]   cd;
        logic [BLOCK_W-1:0] res;
    } core_t;

    core_t core_d;
    core_t core_q;

    logic [SUBKEY_W-1:0] subkey;
    logic [KEY_W-1:0]    cd_next;
    logic                commit;
    logic [HALF_W-1:0]   l_new;
    logic [HALF_W-1:0]   r_new;
    logic [BLOCK_W-1:0]  ip_blk;

    des_key_step u_key (
        .cd_i      (core_q.cd),
        .rnd_i     (core_q.rnd),
        .dec_i     (core_q.dec),
        .subkey_o  (subkey),
        .cd_next_o (cd_next)
    );

    generate
        if (SEQ_ROUND) begin : g_seq
            des_round_seq u_round (
                .clk      (clk),
                .rst_n    (rst_n),
                .en_i     (core_q.busy),
                .l_i      (core_q.l),
                .r_i      (core_q.r),
                .subkey_i (subkey),
                .commit_o (commit),
                .l_o      (l_new),
                .r_o      (r_new)
            );
        end else begin : g_par
            des_round_comb u_round (
                .en_i     (core_q.busy),
                .l_i      (core_q.l),
                .r_i      (core_q.r),
                .subkey_i (subkey),
                .commit_o (commit),
                .l_o      (l_new),
                .r_o      (r_new)
            );
        end
    endgenerate

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        ip_blk      = perm_in(data_i);
        if (!core_q.busy) begin
            if (start_i) begin
                core_d.busy = 1'b1;
                core_d.dec  = decrypt_i;
                core_d.rnd  = '0;
                core_d.l    = ip_blk[BLOCK_W-1:HALF_W];
                core_d.r    = ip_blk[HALF_W-1:0];
                core_d.cd   = key_sel1(key_i);
            end
        end else if (commit) begin
            core_d.l   = l_new;
            core_d.r   = r_new;
            core_d.cd  = cd_next;
            core_d.rnd = core_q.rnd + 1'b1;
            if (core_q.rnd == RND_W'(ROUNDS - 1)) begin
                // Final halves leave unswapped.
                core_d.busy = 1'b0;
                core_d.done = 1'b1;
                core_d.res  = perm_out({r_new, l_new});
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign busy_o   = core_q.busy;
    assign done_o   = core_q.done;
    assign result_o = core_q.res;

endmodule

// File: rtl/des_iter_core_chk.sv
module des_iter_core_chk #(
    parameter int LATENCY = 80
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [63:0] result_o
);

    localparam int CNT_W = $clog2(LATENCY + 2);

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (start_i && !busy_o) begin
            busy_cnt <= '0;
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_cnt == CNT_W'(LATENCY));

    p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_busy_needs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

endmodule

bind des_iter_core des_iter_core_chk #(
    .LATENCY(des_pkg::ROUNDS * (SEQ_ROUND ? des_pkg::SEQ_STEPS : 1))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/des_iter_core_tb.sv
module des_iter_core_tb;

    localparam bit SEQ_ROUND = 1'b1;
    localparam int LAT = 16 * (SEQ_ROUND ? 5 : 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        decrypt_i = 1'b0;
    logic [63:0] data_i = '0;
    logic [63:0] key_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [63:0] result_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [63:0] exp_q [$];
    int          due_q [$];
    string       tag_q [$];

    logic [63:0] m_exp;
    int          m_due;
    string       m_tag;
    bit          prev_done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    des_iter_core #(.SEQ_ROUND(SEQ_ROUND)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .decrypt_i (decrypt_i),
        .data_i    (data_i),
        .key_i     (key_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .result_o  (result_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input bit dec, input logic [63:0] data, input logic [63:0] key,
                          input logic [63:0] exp, input string tag);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        start_i   = 1'b1;
        decrypt_i = dec;
        data_i    = data;
        key_i     = key;
        exp_q.push_back(exp);
        due_q.push_back(cyc + 1 + LAT);
        tag_q.push_back(tag);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // R7: a start pulse with other operands while busy.
    task automatic poke_busy(input logic [63:0] data, input logic [63:0] key);
        @(negedge clk);
        check(busy_o, "R7", "busy before ignored start", 64'(busy_o), 64'd1);
        start_i   = 1'b1;
        decrypt_i = ~decrypt_i;
        data_i    = data;
        key_i     = key;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o || exp_q.size() != 0) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (prev_done) begin
                check(!done_o, "R6", "done longer than one clock", 64'(done_o), 64'd0);
            end
            if (done_o) begin
                check(!busy_o, "R6", "busy while done", 64'(busy_o), 64'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected done", result_o, 64'd0);
                end else begin
                    m_exp = exp_q.pop_front();
                    m_due = due_q.pop_front();
                    m_tag = tag_q.pop_front();
                    check(result_o == m_exp, m_tag, "result", result_o, m_exp);
                    check(cyc == m_due, "R5", "done cycle", 64'(cyc), 64'(m_due));
                end
            end
            prev_done = done_o;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R5: watchdog expired actual=%0d expected=%0d", cyc, 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0, "R1", "busy in reset", 64'(busy_o), 64'd0);
        check(done_o == 1'b0, "R1", "done in reset", 64'(done_o), 64'd0);
        check(result_o == 64'd0, "R1", "result in reset", result_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0, "R1", "flags after reset",
              {62'd0, busy_o, done_o}, 64'd0);
        check(result_o == 64'd0, "R1", "result after reset", result_o, 64'd0);

        // R2 encryption known answers
        run_op(1'b0, 64'h0123456789ABCDEF, 64'h133457799BBCDFF1, 64'h85E813540F0AB405, "R2");
        run_op(1'b0, 64'h8787878787878787, 64'h0E329232EA6D0D73, 64'h0000000000000000, "R2");
        run_op(1'b0, 64'h0000000000000000, 64'h0000000000000000, 64'h8CA64DE9C1B123A7, "R2");
        run_op(1'b0, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h7359B2163E4EDC58, "R2");

        // R3 decryption of the same pairs
        run_op(1'b1, 64'h85E813540F0AB405, 64'h133457799BBCDFF1, 64'h0123456789ABCDEF, "R3");
        run_op(1'b1, 64'h0000000000000000, 64'h0E329232EA6D0D73, 64'h8787878787878787, "R3");
        run_op(1'b1, 64'h7359B2163E4EDC58, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, "R3");

        // R4 parity positions inverted
        run_op(1'b0, 64'h0000000000000000, 64'h0101010101010101, 64'h8CA64DE9C1B123A7, "R4");
        run_op(1'b0, 64'h0123456789ABCDEF, 64'h123557789ABDDEF0, 64'h85E813540F0AB405, "R4");
        run_op(1'b1, 64'h85E813540F0AB405, 64'h123557789ABDDEF0, 64'h0123456789ABCDEF, "R4");

        // R7 starts while busy are dropped
        run_op(1'b0, 64'h0123456789ABCDEF, 64'h133457799BBCDFF1, 64'h85E813540F0AB405, "R7");
        poke_busy(64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF);
        repeat (7) @(negedge clk);
        poke_busy(64'h0000000000000000, 64'h0E329232EA6D0D73);
        run_op(1'b1, 64'h0000000000000000, 64'h0E329232EA6D0D73, 64'h8787878787878787, "R7");
        poke_busy(64'h85E813540F0AB405, 64'h0000000000000000);

        // R8 result holds through idle time
        wait_idle();
        repeat (LAT) @(negedge clk);
        check(result_o == 64'h8787878787878787, "R8", "result held", result_o, 64'h8787878787878787);
        repeat (2 * LAT) @(negedge clk);
        check(result_o == 64'h8787878787878787, "R8", "result held long", result_o, 64'h8787878787878787);
        check(exp_q.size() == 0 && !busy_o, "R5", "all results delivered",
              64'(exp_q.size()), 64'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule